// File: doc/BRIEF.md
# Per-Core Banked Timer Window Router

This block sits between a 32-bit register access port and an array of timer and watchdog register blocks. Each core has one timer and one watchdog. Every access carries the index of the core that issued it. The router decodes the byte address into a 32-byte window and a 5-bit register offset. It then raises the select line of exactly one block, or of none when the access is faulty. One cycle later it returns a response with the read data.

Two alias windows sit at the bottom of the map, and they are banked. The first reaches the issuing core's own timer and the second reaches that core's own watchdog. As a result, the same address lands on a different block depending on which core issues it. Above the aliases, every block also has a fixed global window, laid out as timer then watchdog for core 0, then for core 1, and so on. The router also forwards the blocks' interrupt lines as one vector in that same order.

Top module: `mpwin_router`

## Requirements
- R1: An access to window 0 (byte address 0x00–0x1F) selects block 2·c, and an access to window 1 (0x20–0x3F) selects block 2·c+1, where c is `req_core`. Block 2n is core n's timer and block 2n+1 is core n's watchdog.
- R2: An access to window w, for 2 ≤ w < 2+2·NUM_CORES, selects block w−2. Window 2+2n is therefore core n's timer and window 3+2n is core n's watchdog. The window number is the byte address divided by 32.
- R3: In the cycle the request is presented, `blk_off` equals address bits [4:0], `blk_wr` equals `req_write`, and `blk_wdata` equals `req_wdata`.
- R4: `blk_sel` is one-hot or zero. It is zero whenever `req_valid` is low or the access is faulty.
- R5: `rsp_valid` is high in the cycle after each cycle with `req_valid` high, and low otherwise. For a valid read, `rsp_rdata` carries the word that the selected block drove in the issue cycle.
- R6: An access is faulty if `req_be` is not 4'hF or if address bits [1:0] are not zero.
- R7: An access to window 0 or 1 whose `req_core` is not below NUM_CORES is faulty.
- R8: An access to a window at or above 2+2·NUM_CORES is faulty.
- R9: A faulty access selects no block. Its response has `rsp_err` high for that one response cycle and `rsp_rdata` equal to zero.
- R10: `irq_out[i]` follows `blk_irq[i]` for every block i, in the order timer0, watchdog0, timer1, watchdog1, and so on.
- R11: After reset, `rsp_valid`, `rsp_err` and `rsp_rdata` are all zero.
- R12: A successful write returns a response with `rsp_err` low and `rsp_rdata` equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | 4 | Byte enables; must be 4'hF |
| req_core | input | 2 | Index of the issuing core |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Faulty access flag |
| rsp_rdata | output | 32 | Read data |
| blk_sel | output | 2·NUM_CORES | One-hot block select |
| blk_wr | output | 1 | Write flag to the blocks |
| blk_off | output | 5 | Register offset within the window |
| blk_wdata | output | 32 | Write data to the blocks |
| blk_rdata | input | 64·NUM_CORES | Read data from all blocks; block i occupies bits [32i+31:32i] |
| blk_irq | input | 2·NUM_CORES | Block interrupt lines |
| irq_out | output | 2·NUM_CORES | Ordered interrupt vector |

## Verification
The bench instantiates three cores, so that core index 3 and windows 8 and above are out of range.

- **Alias banking.** The bench sends the same alias address from every core. A router that ignored `req_core` would hit block 0 or 1 for all of them. A router that swapped the timer and watchdog order would return the neighbouring block's data.
- **Window edges.** The bench walks the edges of the map: the last mapped direct window, the first unmapped window, and an alias access from a core that does not exist. A decoder with an off-by-one compare would either select a phantom block or reject a valid one.
- **Faulty sizes and alignment.** The bench sends partial byte enables and misaligned addresses to windows that are otherwise valid. A design that leaked such accesses would pulse a select line and return nonzero data.
- **Back-to-back traffic.** The bench issues accesses on consecutive cycles. This catches read data taken from the wrong cycle's selection.

// File: rtl/mpwin_pkg.sv
// Package: shared constants and the decoded-route record used by the
// window router. Assumes at most four cores, so at most eight blocks.
package mpwin_pkg;
    localparam int DATA_W    = 32;
    localparam int BE_W      = DATA_W / 8;
    localparam int OFF_W     = 5;
    localparam int MAX_CORES = 4;
    localparam int CORE_W    = $clog2(MAX_CORES);
    localparam int BLK_W     = CORE_W + 1;
    localparam int N_ALIAS   = 2;

    // Route record produced by the decoder.
    typedef struct packed {
        logic             fault;
        logic [BLK_W-1:0] blk;
    } route_t;
endpackage

// File: rtl/mpwin_decode.sv
// Decoder: turns a window number, address low bits, byte enables and the
// core index into a block index and a fault flag.
// Assumes the window field is wide enough to hold every mapped window.
module mpwin_decode
    import mpwin_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int WIN_W     = 4
) (
    input  logic [WIN_W-1:0]  win,
    input  logic [1:0]        addr_lo,
    input  logic [BE_W-1:0]   be,
    input  logic [CORE_W-1:0] core,
    output route_t            route
);
    localparam int NUM_WIN = N_ALIAS + 2 * NUM_CORES;

    logic             bad_size;
    logic             is_alias;
    logic             core_bad;
    logic             unmapped;
    logic [WIN_W-1:0] direct_idx;

    // Classify the access and find the fault conditions.
    always_comb begin
        bad_size   = (be != {BE_W{1'b1}}) || (addr_lo != 2'b00);
        is_alias   = (win < WIN_W'(N_ALIAS));
        core_bad   = ({1'b0, core} >= (CORE_W+1)'(NUM_CORES));
        unmapped   = (win >= WIN_W'(NUM_WIN));
        direct_idx = win - WIN_W'(N_ALIAS);
    end

    // Build the route: alias windows are banked by the core index.
    always_comb begin
        route.fault = bad_size || unmapped || (is_alias && core_bad);
        if (is_alias) begin
            route.blk = {core, win[0]};
        end else begin
            route.blk = direct_idx[BLK_W-1:0];
        end
    end
endmodule

// File: rtl/mpwin_select.sv
// Select generator: drives one select line per block from the decoded route.
// Assumes the route is stable for the whole request cycle.
module mpwin_select
    import mpwin_pkg::*;
#(
    parameter int NUM_BLK = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  route_t             route,
    output logic [NUM_BLK-1:0] blk_sel
);
    // One comparator per block; a fault or an idle cycle selects nothing.
    for (genvar i = 0; i < NUM_BLK; i++) begin : g_sel
        assign blk_sel[i] = req_valid && !route.fault && (route.blk == BLK_W'(i));
    end

    assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(blk_sel));
    assert_fault_no_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        route.fault |-> (blk_sel == '0));
endmodule

// File: rtl/mpwin_resp.sv
// Response stage: picks the selected block's read word in the issue cycle
// and registers it together with the valid and error flags.
// Assumes the blocks drive their read data combinationally from the offset.
module mpwin_resp
    import mpwin_pkg::*;
#(
    parameter int NUM_BLK = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  route_t                    route,
    input  logic [NUM_BLK*DATA_W-1:0] blk_rdata,
    output logic                      rsp_valid,
    output logic                      rsp_err,
    output logic [DATA_W-1:0]         rsp_rdata
);
    logic [DATA_W-1:0] picked;
    logic [DATA_W-1:0] next_data;

    // Read-data multiplexer across the block array.
    always_comb begin
        picked = '0;
        for (int i = 0; i < NUM_BLK; i++) begin
            if (route.blk == BLK_W'(i)) begin
                picked = blk_rdata[i*DATA_W +: DATA_W];
            end
        end
    end

    // Only a good read returns data; writes and faults return zero.
    always_comb begin
        next_data = (req_valid && !req_write && !route.fault) ? picked : '0;
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && route.fault;
            rsp_rdata <= next_data;
        end
    end

    assert_rsp_follows_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_rsp_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_err_zero_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));
    assert_write_zero_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == '0));
endmodule

// File: rtl/mpwin_router.sv
// Top: banked register window router for per-core timer/watchdog blocks.
// Windows 0 and 1 alias the issuing core's timer and watchdog; windows
// 2+2n and 3+2n reach core n's timer and watchdog directly.
// Assumes NUM_CORES in 1..4 and an address wide enough for every window.
module mpwin_router
    import mpwin_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [3:0]                  req_be,
    input  logic [1:0]                  req_core,
    input  logic [31:0]                 req_wdata,
    output logic                        rsp_valid,
    output logic                        rsp_err,
    output logic [31:0]                 rsp_rdata,
    output logic [2*NUM_CORES-1:0]      blk_sel,
    output logic                        blk_wr,
    output logic [4:0]                  blk_off,
    output logic [31:0]                 blk_wdata,
    input  logic [64*NUM_CORES-1:0]     blk_rdata,
    input  logic [2*NUM_CORES-1:0]      blk_irq,
    output logic [2*NUM_CORES-1:0]      irq_out
);
    localparam int NUM_BLK = 2 * NUM_CORES;
    localparam int NUM_WIN = N_ALIAS + NUM_BLK;
    localparam int WIN_W   = ADDR_W - OFF_W;
    localparam int MIN_AW  = OFF_W + $clog2(NUM_WIN);

    // Reject configurations outside the supported range.
    if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin : g_bad_cores
        $error("mpwin_router: NUM_CORES must be 1..4");
    end
    if (ADDR_W < MIN_AW) begin : g_bad_addr
        $error("mpwin_router: ADDR_W too small for the window map");
    end

    route_t route;

    // Decode the window, low bits, byte enables and core into a route.
    mpwin_decode #(
        .NUM_CORES (NUM_CORES),
        .WIN_W     (WIN_W)
    ) u_decode (
        .win     (req_addr[ADDR_W-1:OFF_W]),
        .addr_lo (req_addr[1:0]),
        .be      (req_be),
        .core    (req_core),
        .route   (route)
    );

    // Drive the block select lines.
    mpwin_select #(
        .NUM_BLK (NUM_BLK)
    ) u_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .route     (route),
        .blk_sel   (blk_sel)
    );

    // Registered response path.
    mpwin_resp #(
        .NUM_BLK (NUM_BLK)
    ) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .route     (route),
        .blk_rdata (blk_rdata),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

    // Shared request fields go to every block.
    assign blk_wr    = req_write;
    assign blk_off   = req_addr[OFF_W-1:0];
    assign blk_wdata = req_wdata;

    // Interrupt lines keep the block order: timer n, then watchdog n.
    for (genvar i = 0; i < NUM_BLK; i++) begin : g_irq
        assign irq_out[i] = blk_irq[i];
    end

    assert_bad_size_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_be != 4'hF || req_addr[1:0] != 2'b00)) |=> rsp_err);
    assert_bad_core_alias_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[ADDR_W-1:OFF_W] < WIN_W'(N_ALIAS)
         && {1'b0, req_core} >= 3'(NUM_CORES)) |-> (blk_sel == '0));
    assert_unmapped_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[ADDR_W-1:OFF_W] >= WIN_W'(NUM_WIN)) |=> rsp_err);
    assert_reset_quiet_R11: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !rsp_err && rsp_rdata == '0));
endmodule

// File: tb/mpwin_router_test.sv
`timescale 1ns/1ps
module mpwin_router_test;
    localparam int NC = 3;
    localparam int NB = 2 * NC;
    localparam int AW = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic [3:0]        req_be = 4'hF;
    logic [1:0]        req_core = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid, rsp_err;
    logic [31:0]       rsp_rdata;
    logic [NB-1:0]     blk_sel;
    logic              blk_wr;
    logic [4:0]        blk_off;
    logic [31:0]       blk_wdata;
    logic [NB*32-1:0]  blk_rdata;
    logic [NB-1:0]     blk_irq = '0;
    logic [NB-1:0]     irq_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mpwin_router #(.NUM_CORES(NC), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_core(req_core),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .blk_sel(blk_sel), .blk_wr(blk_wr),
        .blk_off(blk_off), .blk_wdata(blk_wdata), .blk_rdata(blk_rdata),
        .blk_irq(blk_irq), .irq_out(irq_out)
    );

    // Behavioural stand-in for the blocks: each returns a tagged word per offset.
    function automatic logic [31:0] blk_word(int b, logic [4:0] off);
        return 32'hA500_0000 | (32'(b) << 16) | 32'(off) | 32'h0000_1200;
    endfunction
    for (genvar i = 0; i < NB; i++) begin : g_blk
        assign blk_rdata[i*32 +: 32] = blk_word(i, blk_off);
    end

    // Reference decode from the requirements; -1 means a faulty access.
    function automatic int ref_block(int a, int c, logic [3:0] be);
        int w = a / 32;
        if (be != 4'hF || (a % 4) != 0) return -1;      // R6
        if (w < 2) return (c < NC) ? 2 * c + w : -1;     // R1, R7
        if (w < 2 + 2 * NC) return w - 2;                // R2
        return -1;                                       // R8
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access: check the same-cycle block side, then the registered response.
    task automatic access(int a, int c, logic [3:0] be, bit wr, logic [31:0] wd, string tag);
        int eb;
        logic [31:0] exp_sel, exp_data;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a);
        req_core = 2'(c); req_be = be; req_wdata = wd;
        #1;
        eb = ref_block(a, c, be);
        exp_sel = (eb < 0) ? 32'd0 : (32'd1 << eb);
        chk({tag, " sel R4"}, 32'(blk_sel), exp_sel);
        chk("R3 offset", 32'(blk_off), 32'(a % 32));
        chk("R3 write flag", 32'(blk_wr), 32'(wr));
        chk("R3 wdata", blk_wdata, wd);
        exp_data = (eb >= 0 && !wr) ? blk_word(eb, 5'(a % 32)) : 32'd0;
        @(posedge clk); #1;
        chk("R5 rsp_valid", 32'(rsp_valid), 32'd1);
        chk({tag, " rsp_err R9"}, 32'(rsp_err), (eb < 0) ? 32'd1 : 32'd0);
        chk({tag, " rdata R5 R12"}, rsp_rdata, exp_data);
        req_valid = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk); #1;
        chk("R5 no response when idle", 32'(rsp_valid), 32'd0);
        chk("R9 no error when idle", 32'(rsp_err), 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R11 reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R11 reset rsp_err", 32'(rsp_err), 32'd0);
        chk("R11 reset rdata", rsp_rdata, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        idle();
        // R1: same alias address from each core lands on that core's blocks.
        for (int c = 0; c < NC; c++) begin
            access(32'h04, c, 4'hF, 1'b0, 32'h0, "R1 alias timer");
            access(32'h2C, c, 4'hF, 1'b0, 32'h0, "R1 alias watchdog");
        end
        // R2: every direct window, read and write.
        for (int w = 2; w < 2 + 2 * NC; w++) begin
            access(w * 32 + 8, 0, 4'hF, 1'b0, 32'h0, "R2 direct read");
            access(w * 32 + 12, 1, 4'hF, 1'b1, 32'hC0DE_0000 + w, "R2 direct write R12");
        end
        // R7: alias from a core that does not exist.
        access(32'h00, 3, 4'hF, 1'b0, 32'h0, "R7 alias bad core");
        access(32'h20, 3, 4'hF, 1'b1, 32'h1234_5678, "R7 alias bad core write");
        // R8: first unmapped window and far above.
        access((2 + 2 * NC) * 32, 0, 4'hF, 1'b0, 32'h0, "R8 first unmapped");
        access(2047 * 2, 0, 4'hF, 1'b0, 32'h0, "R8 high window");
        // R6: partial enables and misaligned addresses on valid windows.
        access(32'h40, 0, 4'h3, 1'b0, 32'h0, "R6 partial be");
        access(32'h42, 0, 4'hF, 1'b1, 32'hFFFF_FFFF, "R6 misaligned");
        access(32'h01, 1, 4'hF, 1'b0, 32'h0, "R6 misaligned alias");
        // Back-to-back mix with an idle gap.
        access(32'hFC, 2, 4'hF, 1'b0, 32'h0, "R2 last direct window");
        access(32'h3C, 2, 4'hF, 1'b0, 32'h0, "R1 alias watchdog core2");
        idle();
        access(32'h10, 1, 4'hF, 1'b0, 32'h0, "R1 alias after idle");
        // R10: interrupt vector ordering under several patterns.
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            blk_irq = (p == 0) ? NB'(1) : (p == 1) ? NB'(2) : (p == 2) ? NB'(6'b101010) : NB'(6'b010101);
            #1;
            chk("R10 irq order", 32'(irq_out), 32'(blk_irq));
        end
        // R11: reset mid-run clears the response.
        @(negedge clk);
        req_valid = 1'b1; req_addr = AW'(32'h40); req_core = 0; req_be = 4'hF; req_write = 1'b0;
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R11 reset overrides request", 32'(rsp_valid), 32'd0);
        chk("R11 reset clears rdata", rsp_rdata, 32'd0);
        req_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule